// File: doc/BRIEF.md
# Strobe-Clocked Slave Byte FIFO Endpoint

This block sits on the receiving side of an external device that pushes bytes through an asynchronous, active-low write strobe. It brings the write strobe, the chip select and an active-low packet-end strobe into its own clock domain through two-flop synchronisers, and then looks for their rising edges. Each rising edge of the write strobe, seen while chip select is active, stores the byte last sampled from the data bus into one of several byte FIFOs. The address lines pick that FIFO. The FIFO's write pointer then moves on to the next free slot.

A rising edge of the packet-end strobe closes the bytes written so far into a packet. The packet may be short, and it may even be empty. The packet's length goes into a small per-FIFO length queue. A downstream read port chooses a FIFO and drains it one byte per read pulse. It only ever sees bytes that belong to closed packets, and it gets the packet length and a last-byte marker along with them.

The external writer must keep the data and address lines stable while the strobe is low and for two clock cycles after the strobe rises. Each strobe level must last at least three clock cycles.

Top module: `strobe_fifo_slave`

## Requirements
- R1: After reset every FIFO reports empty=1, full=0 and overflow=0, and the read port reports no packet available (rd_pkt_valid=0).
- R2: A rising edge of wr_n seen while cs_n is low stores the byte on wr_data into the FIFO chosen by fifo_sel. Bytes come out of the read port in the order they were written.
- R3: A write strobe or a packet-end strobe seen while cs_n is high changes no FIFO contents, no flag and no packet state.
- R4: Within 4 clock cycles of a rising strobe edge, the FIFO flags show the new fill level. empty=1 exactly when the FIFO holds no bytes, and full=1 exactly when it holds DEPTH bytes. Both committed and uncommitted bytes count toward the fill level.
- R5: A write to a full FIFO is dropped and sets that FIFO's overflow bit. The bit stays set until reset, and the bytes already stored are unchanged.
- R6: A rising edge of pktend_n while cs_n is low closes all uncommitted bytes of the selected FIFO into a packet. Within 4 cycles, rd_pkt_valid=1 for that FIFO and rd_pkt_len equals the packet's byte count.
- R7: A packet end with no uncommitted bytes queues a packet of length 0. One read pulse removes it and returns no byte.
- R8: rd_pkt_valid is 0 while the FIFO picked by rd_sel has no committed packet, and rd_en then has no effect. A read pulse consumes one byte of the head packet. rd_last=1 on the packet's final byte, and after that byte the next packet's length appears.
- R9: A packet end when the FIFO's length queue already holds LQ_DEPTH packets is dropped and sets that FIFO's overflow bit.
- R10: Writes, packet ends and reads aimed at one FIFO leave the flags and packets of every other FIFO unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Asynchronous write strobe, active low; the byte is stored on its rising edge |
| cs_n | input | 1 | Asynchronous chip select, active low |
| pktend_n | input | 1 | Asynchronous packet-end strobe, active low; the commit happens on its rising edge |
| fifo_sel | input | SEL_W | FIFO chosen for writes and packet ends |
| wr_data | input | DATA_W | Write data bus |
| rd_sel | input | SEL_W | FIFO chosen by the read port |
| rd_en | input | 1 | Read pulse, one byte or one empty packet per cycle |
| fifo_full | output | NUM_FIFOS | Per-FIFO full flag |
| fifo_empty | output | NUM_FIFOS | Per-FIFO empty flag |
| fifo_overflow | output | NUM_FIFOS | Per-FIFO sticky overflow bit |
| rd_pkt_valid | output | 1 | The chosen FIFO has at least one committed packet |
| rd_pkt_len | output | CNT_W | Length of the head packet |
| rd_data | output | DATA_W | Head byte of the chosen FIFO |
| rd_last | output | 1 | The head byte is the last one of its packet |

## Verification
The bench aims at four corner cases:
- A FIFO filled to exactly its depth, followed by one more write. A design with an off-by-one boundary would either drop the last good byte or overwrite the oldest stored byte.
- A packet end with nothing pending, followed by a read of that empty packet. A faulty design would hand out a stray byte or stall the length queue.
- A length queue pushed past its capacity, which must be rejected without disturbing the packets already queued.
- Strobes sent while chip select is high, together with traffic on a second FIFO. Either of these would show up as a changed flag if chip select gating or address decoding were broken.

Constrained random traffic then mixes all of these cases and compares every byte, length and last marker with a queue model.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    typedef struct packed {
        logic full;
        logic empty;
        logic overflow;
    } lane_flags_t;

    function automatic int unsigned wrap_inc(input int unsigned ptr, input int unsigned limit);
        return (ptr + 1 == limit) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] level
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
            end else begin
                meta_q <= async_in[i];
                sync_q <= meta_q;
            end
        end
        assign level[i] = sync_q;
    end
endmodule

// File: rtl/edge_rise.sv
module edge_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/fifo_lane.sv
module fifo_lane
    import strobe_fifo_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 16,
    parameter int LQ_DEPTH = 4,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int LQP_W   = $clog2(LQ_DEPTH),
    localparam int LQC_W   = $clog2(LQ_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit_stb,
    input  logic              rd_pop,
    output lane_flags_t       flags,
    output logic              pkt_valid,
    output logic [CNT_W-1:0]  pkt_len,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  lenq [LQ_DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic [CNT_W-1:0]  count, pending, consumed;
    logic [LQP_W-1:0]  lq_wp, lq_rp;
    logic [LQC_W-1:0]  lq_cnt;
    logic              ovf_q;

    logic             wr_ok, lq_full, push_len, pop_byte, pop_len;
    logic [CNT_W-1:0] head_len, remain;

    always_comb begin
        wr_ok    = wr_stb && (count != CNT_W'(DEPTH));
        lq_full  = (lq_cnt == LQC_W'(LQ_DEPTH));
        push_len = commit_stb && !lq_full;
        head_len = lenq[lq_rp];
        remain   = head_len - consumed;
        pop_byte = rd_pop && (lq_cnt != '0) && (head_len != '0);
        pop_len  = rd_pop && (lq_cnt != '0) &&
                   ((head_len == '0) || (remain == CNT_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_data;
        if (push_len) lenq[lq_wp] <= pending + CNT_W'(wr_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            pending  <= '0;
            consumed <= '0;
            lq_wp    <= '0;
            lq_rp    <= '0;
            lq_cnt   <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (wr_ok)
                wptr <= PTR_W'(wrap_inc(32'(wptr), DEPTH));
            if (pop_byte)
                rptr <= PTR_W'(wrap_inc(32'(rptr), DEPTH));
            count <= count + CNT_W'(wr_ok) - CNT_W'(pop_byte);
            if ((wr_stb && !wr_ok) || (commit_stb && lq_full))
                ovf_q <= 1'b1;
            if (push_len)   pending <= '0;
            else if (wr_ok) pending <= pending + CNT_W'(1);
            if (pop_len)       consumed <= '0;
            else if (pop_byte) consumed <= consumed + CNT_W'(1);
            if (push_len)
                lq_wp <= LQP_W'(wrap_inc(32'(lq_wp), LQ_DEPTH));
            if (pop_len)
                lq_rp <= LQP_W'(wrap_inc(32'(lq_rp), LQ_DEPTH));
            lq_cnt <= lq_cnt + LQC_W'(push_len) - LQC_W'(pop_len);
        end
    end

    assign flags.full     = (count == CNT_W'(DEPTH));
    assign flags.empty    = (count == '0);
    assign flags.overflow = ovf_q;
    assign pkt_valid      = (lq_cnt != '0);
    assign pkt_len        = head_len;
    assign rd_data        = mem[rptr];
    assign rd_last        = (remain <= CNT_W'(1));

    assert_fill_bound_R4: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && flags.full) |=> ($stable(wptr) && flags.overflow));

    assert_committed_only_R8: assert property (@(posedge clk) disable iff (rst)
        pending <= count);

    assert_empty_packet_R7: assert property (@(posedge clk) disable iff (rst)
        (commit_stb && !lq_full && !wr_stb && pending == '0 && !pop_len)
        |=> (lq_cnt == $past(lq_cnt) + LQC_W'(1)));
endmodule

// File: rtl/strobe_fifo_slave.sv
module strobe_fifo_slave
    import strobe_fifo_pkg::*;
#(
    parameter int NUM_FIFOS = 2,
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 16,
    parameter int LQ_DEPTH  = 4,
    localparam int SEL_W    = (NUM_FIFOS > 1) ? $clog2(NUM_FIFOS) : 1,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_n,
    input  logic                 cs_n,
    input  logic                 pktend_n,
    input  logic [SEL_W-1:0]     fifo_sel,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [SEL_W-1:0]     rd_sel,
    input  logic                 rd_en,
    output logic [NUM_FIFOS-1:0] fifo_full,
    output logic [NUM_FIFOS-1:0] fifo_empty,
    output logic [NUM_FIFOS-1:0] fifo_overflow,
    output logic                 rd_pkt_valid,
    output logic [CNT_W-1:0]     rd_pkt_len,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_last
);
    logic [2:0] lvl;
    logic [1:0] rise;
    logic       wr_s, cs_s, pe_s;

    strobe_sync #(.N(3)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({pktend_n, cs_n, wr_n}),
        .level    (lvl)
    );

    assign wr_s = lvl[0];
    assign cs_s = lvl[1];
    assign pe_s = lvl[2];

    edge_rise #(.N(2)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .level ({pe_s, wr_s}),
        .rise  (rise)
    );

    logic [DATA_W-1:0] cap_data;
    logic [SEL_W-1:0]  cap_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_data <= '0;
            cap_sel  <= '0;
        end else begin
            if (!wr_s)          cap_data <= wr_data;
            if (!wr_s || !pe_s) cap_sel  <= fifo_sel;
        end
    end

    logic [NUM_FIFOS-1:0] wr_vec, commit_vec;
    lane_flags_t          lane_flags [NUM_FIFOS];
    logic                 lane_valid [NUM_FIFOS];
    logic [CNT_W-1:0]     lane_len   [NUM_FIFOS];
    logic [DATA_W-1:0]    lane_data  [NUM_FIFOS];
    logic                 lane_last  [NUM_FIFOS];

    for (genvar i = 0; i < NUM_FIFOS; i++) begin : g_lane
        assign wr_vec[i]     = rise[0] && !cs_s && (cap_sel == SEL_W'(i));
        assign commit_vec[i] = rise[1] && !cs_s && (cap_sel == SEL_W'(i));

        fifo_lane #(
            .DATA_W   (DATA_W),
            .DEPTH    (DEPTH),
            .LQ_DEPTH (LQ_DEPTH)
        ) u_lane (
            .clk        (clk),
            .rst        (rst),
            .wr_stb     (wr_vec[i]),
            .wr_data    (cap_data),
            .commit_stb (commit_vec[i]),
            .rd_pop     (rd_en && (rd_sel == SEL_W'(i))),
            .flags      (lane_flags[i]),
            .pkt_valid  (lane_valid[i]),
            .pkt_len    (lane_len[i]),
            .rd_data    (lane_data[i]),
            .rd_last    (lane_last[i])
        );

        assign fifo_full[i]     = lane_flags[i].full;
        assign fifo_empty[i]    = lane_flags[i].empty;
        assign fifo_overflow[i] = lane_flags[i].overflow;
    end

    always_comb begin
        rd_pkt_valid = 1'b0;
        rd_pkt_len   = '0;
        rd_data      = '0;
        rd_last      = 1'b0;
        for (int i = 0; i < NUM_FIFOS; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                rd_pkt_valid = lane_valid[i];
                rd_pkt_len   = lane_len[i];
                rd_data      = lane_data[i];
                rd_last      = lane_last[i];
            end
        end
    end

    assert_single_target_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_vec) && $onehot0(commit_vec));
endmodule

// File: tb/test_strobe_fifo_slave.sv
`timescale 1ns/1ps
module test_strobe_fifo_slave;
    localparam int NF = 2;
    localparam int DEPTH = 16;
    localparam int LQ = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_n = 1'b1, cs_n = 1'b0, pktend_n = 1'b1;
    logic [0:0] fifo_sel = '0, rd_sel = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] fifo_full, fifo_empty, fifo_overflow;
    logic       rd_pkt_valid, rd_last;
    logic [4:0] rd_pkt_len;
    logic [7:0] rd_data;

    always #2 clk = ~clk;

    strobe_fifo_slave #(.NUM_FIFOS(NF), .DATA_W(8), .DEPTH(DEPTH), .LQ_DEPTH(LQ)) i_strobe_fifo_slave (
        .clk(clk), .rst(rst), .wr_n(wr_n), .cs_n(cs_n), .pktend_n(pktend_n),
        .fifo_sel(fifo_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_en(rd_en),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_overflow(fifo_overflow),
        .rd_pkt_valid(rd_pkt_valid), .rd_pkt_len(rd_pkt_len), .rd_data(rd_data),
        .rd_last(rd_last)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    int mq [NF][$];
    int lq [NF][$];
    int pend [NF];
    int cons [NF];
    bit ovf [NF];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_full(int f);
        return (mq[f].size() == DEPTH) ? 1 : 0;
    endfunction

    function automatic int exp_empty(int f);
        return (mq[f].size() == 0) ? 1 : 0;
    endfunction

    task automatic model_clear();
        for (int f = 0; f < NF; f++) begin
            mq[f].delete(); lq[f].delete();
            pend[f] = 0; cons[f] = 0; ovf[f] = 0;
        end
    endtask

    task automatic check_flags(input string req);
        for (int f = 0; f < NF; f++) begin
            chk({req, " full"}, int'(fifo_full[f]), exp_full(f));
            chk({req, " empty"}, int'(fifo_empty[f]), exp_empty(f));
            chk({req, " overflow"}, int'(fifo_overflow[f]), int'(ovf[f]));
        end
    endtask

    task automatic check_head(input int f, input string req);
        rd_sel = f[0:0];
        #1;
        chk({req, " pkt_valid"}, int'(rd_pkt_valid), (lq[f].size() != 0) ? 1 : 0);
        if (lq[f].size() != 0) begin
            chk({req, " pkt_len"}, int'(rd_pkt_len), lq[f][0]);
            chk({req, " last"}, int'(rd_last), ((lq[f][0] - cons[f]) <= 1) ? 1 : 0);
            if (lq[f][0] != 0) chk("R2 data order", int'(rd_data), mq[f][0]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_n = 1'b1; pktend_n = 1'b1; cs_n = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic do_write(input int f, input int d, input bit csn);
        @(negedge clk);
        fifo_sel = f[0:0]; wr_data = d[7:0]; cs_n = csn;
        @(negedge clk); wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        if (!csn) begin
            if (mq[f].size() == DEPTH) ovf[f] = 1;
            else begin mq[f].push_back(d & 8'hFF); pend[f]++; end
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        cs_n = 1'b0;
        check_flags(csn ? "R3" : "R4");
    endtask

    task automatic do_pktend(input int f, input bit csn);
        @(negedge clk);
        fifo_sel = f[0:0]; cs_n = csn;
        @(negedge clk); pktend_n = 1'b0;
        repeat (3) @(negedge clk);
        pktend_n = 1'b1;
        if (!csn) begin
            if (lq[f].size() == LQ) ovf[f] = 1;
            else begin lq[f].push_back(pend[f]); pend[f] = 0; end
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        cs_n = 1'b0;
        check_flags(csn ? "R3" : "R9");
        check_head(f, csn ? "R3" : "R6");
    endtask

    task automatic do_read(input int f);
        @(negedge clk);
        check_head(f, "R8");
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        if (lq[f].size() != 0) begin
            if (lq[f][0] == 0) void'(lq[f].pop_front());
            else begin
                void'(mq[f].pop_front());
                cons[f]++;
                if (cons[f] == lq[f][0]) begin void'(lq[f].pop_front()); cons[f] = 0; end
            end
        end
        check_flags("R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        model_clear();
        do_reset();
        @(negedge clk);
        check_flags("R1");
        check_head(0, "R1");
        check_head(1, "R1");

        // R2/R6: four-byte short packet, invisible until committed (R8)
        for (int k = 0; k < 4; k++) do_write(0, 8'hA1 + k, 1'b0);
        check_head(0, "R8 uncommitted");
        do_pktend(0, 1'b0);
        for (int k = 0; k < 4; k++) do_read(0);
        check_head(0, "R8 drained");

        // R3: strobes with chip select high
        do_write(0, 8'h55, 1'b1);
        do_pktend(0, 1'b1);

        // R7: zero-length packet
        do_pktend(0, 1'b0);
        do_read(0);
        check_head(0, "R7 removed");

        // R5/R10: fill FIFO 1, then overflow it
        for (int k = 0; k < DEPTH; k++) do_write(1, 8'h10 + k, 1'b0);
        do_write(1, 8'hEE, 1'b0);
        do_pktend(1, 1'b0);
        for (int k = 0; k < DEPTH; k++) do_read(1);

        // R9: length queue overrun on FIFO 0
        for (int k = 0; k < LQ + 1; k++) do_pktend(0, 1'b0);
        for (int k = 0; k < LQ; k++) do_read(0);

        // constrained random traffic
        do_reset();
        seed = int'($urandom(32'd2024));
        for (int n = 0; n < 400; n++) begin
            int op, f;
            op = int'($urandom_range(99));
            f = int'($urandom_range(NF - 1));
            if (op < 60)      do_write(f, int'($urandom_range(255)), ($urandom_range(9) == 0));
            else if (op < 72) do_pktend(f, ($urandom_range(9) == 0));
            else              do_read(f);
        end
        for (int f = 0; f < NF; f++) begin
            do_pktend(f, 1'b0);
            while (lq[f].size() != 0) do_read(f);
            check_head(f, "R8 final");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule